// File: doc/BRIEF.md
# MDIO Management Frame Responder

This block is the device-side end of a two-wire serial management link. It runs directly on the management clock and samples the shared data line on every rising edge. It waits for an idle period, then decodes each 32-bit frame. A frame carries a start pattern, an opcode, a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits, all sent most significant bit first. The device address is compared with a strap input.

A matching write frame is stored in a small internal register file. The commit is also shown to the surrounding logic as a one-cycle strobe with its address and data. A matching read frame makes the block take over the shared line partway through the frame. It drives the second turnaround bit low, then sends the stored 16-bit value, and then releases the line. A frame that is malformed or addressed to another device never causes the block to drive the line, and the block then waits for a fresh idle period.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mdio_oe` and `rf_wr_o` are 0.
- R2: A frame is only recognised when at least IDLE_LEN consecutive 1 samples come before the 0 that forms bit position 0. A frame that follows a shorter run of ones causes no drive and no write.
- R3: A frame with start bits 0,1, opcode 0,1 (write), a device address equal to `phy_addr_i` and an in-range register address raises `rf_wr_o` for exactly one cycle, starting with the cycle after D0 (bit position 31) is sampled. During that cycle `rf_waddr_o` holds the register address and `rf_wdata_o` holds the 16 data bits with the first received bit as bit 15. A later read of that address returns the value.
- R4: For a matching read (opcode 1,0), `mdio_oe` stays 0 during bit position 14. From the rising edge that samples bit 14, the line is driven for bit position 15 with value 0, and then for bit positions 16 to 31 with the register value, bit 15 first. Each bit changes on the rising edge that ends the previous bit.
- R5: `mdio_oe` falls on the rising edge that samples bit position 31, after exactly 17 driven bit periods.
- R6: A frame whose device address differs from `phy_addr_i` is never driven and writes nothing.
- R7: Opcodes 0,0 and 1,1 are rejected. There is no drive and no write.
- R8: A frame whose second start bit is 0 is rejected. There is no drive and no write.
- R9: A register address of 2**REG_AW or above is out of range. A write to it raises no strobe and leaves every stored register unchanged. A read of it is driven normally and returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr_i | input | 5 | Strapped device address |
| mdio_i | input | 1 | Sampled value of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line pad |
| rf_wr_o | output | 1 | One-cycle register write strobe |
| rf_waddr_o | output | REG_AW | Address of the committed write |
| rf_wdata_o | output | 16 | Data of the committed write |

## Verification
The bench builds the block with REG_AW = 3 and IDLE_LEN = 32. With only eight registers stored, a 5-bit register address of 12 falls out of range, so dropped writes and zero reads can be shown. That address also aliases register 4 in its low bits, so a wrongly committed write would show up as a corrupted read of register 4. Keeping the idle length at 32 lets a short 10-bit preamble be placed right after a frame that ends in 0, so the count of ones cannot pass the threshold.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  localparam int FRAME_LEN = 32;
  localparam int DATA_W    = 16;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int POS_W     = $clog2(FRAME_LEN);

  // bit positions inside a frame (position 0 is the first start bit)
  localparam logic [POS_W-1:0] POS_START1  = POS_W'(1);
  localparam logic [POS_W-1:0] POS_OP_END  = POS_W'(3);
  localparam logic [POS_W-1:0] POS_PHY_END = POS_W'(8);
  localparam logic [POS_W-1:0] POS_REG_END = POS_W'(13);
  localparam logic [POS_W-1:0] POS_TA1     = POS_W'(14);
  localparam logic [POS_W-1:0] POS_TA2     = POS_W'(15);
  localparam logic [POS_W-1:0] POS_DATA0   = POS_W'(16);
  localparam logic [POS_W-1:0] POS_LAST    = POS_W'(FRAME_LEN - 1);

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic {ST_HUNT, ST_FRAME} fsm_state_t;

endpackage

// File: rtl/mdio_idle_det.sv
module mdio_idle_det #(
  parameter int IDLE_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic clear_i,
  output logic armed_o
);
  localparam int CW = $clog2(IDLE_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_LEN);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q <= '0;
    end else if (clear_i || !bit_i) begin
      ones_q <= '0;
    end else if (ones_q != LIMIT) begin
      ones_q <= ones_q + CW'(1);
    end
  end

  assign armed_o = (ones_q == LIMIT);
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_i,
  input  logic                armed_i,
  input  logic [PHY_W-1:0]    phy_i,
  output logic                in_frame_o,
  output logic                rd_en_o,
  output logic                range_ok_o,
  output logic [REG_AW-1:0]   reg_addr_o,
  output logic                tx_start_o,
  output logic                tx_load_o,
  output logic                tx_stop_o,
  output logic                commit_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                stb_o,
  output logic [REG_AW-1:0]   stb_addr_o,
  output logic [DATA_W-1:0]   stb_data_o
);
  fsm_state_t          state_q;
  logic [POS_W-1:0]    pos_q;
  logic [REG_W-1:0]    hdr_q;
  logic [DATA_W-2:0]   dsh_q;
  logic                is_rd_q;
  logic                is_wr_q;
  logic                stb_q;
  logic [REG_AW-1:0]   stb_addr_q;
  logic [DATA_W-1:0]   stb_data_q;
  logic                range_ok;
  logic                framing;

  generate
    if (REG_AW < REG_W) begin : g_part_map
      assign range_ok = (hdr_q[REG_W-1:REG_AW] == '0);
    end else begin : g_full_map
      assign range_ok = 1'b1;
    end
  endgenerate

  assign framing    = (state_q == ST_FRAME);
  assign in_frame_o = framing;
  assign reg_addr_o = hdr_q[REG_AW-1:0];
  assign range_ok_o = range_ok;
  assign rd_en_o    = framing && (pos_q == POS_TA1) && is_rd_q;
  assign tx_start_o = rd_en_o;
  assign tx_load_o  = framing && (pos_q == POS_TA2) && is_rd_q;
  assign tx_stop_o  = framing && (pos_q == POS_LAST);
  assign commit_o   = tx_stop_o && is_wr_q && range_ok;
  assign wdata_o    = {dsh_q, bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT;
      pos_q      <= '0;
      hdr_q      <= '0;
      dsh_q      <= '0;
      is_rd_q    <= 1'b0;
      is_wr_q    <= 1'b0;
      stb_q      <= 1'b0;
      stb_addr_q <= '0;
      stb_data_q <= '0;
    end else begin
      stb_q <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          is_rd_q <= 1'b0;
          is_wr_q <= 1'b0;
          if (!bit_i && armed_i) begin
            state_q <= ST_FRAME;
            pos_q   <= POS_START1;
          end
        end
        ST_FRAME: begin
          pos_q <= pos_q + POS_W'(1);
          if (pos_q <= POS_REG_END) hdr_q <= {hdr_q[REG_W-2:0], bit_i};
          if (pos_q >= POS_DATA0)   dsh_q <= {dsh_q[DATA_W-3:0], bit_i};
          if (pos_q == POS_START1 && !bit_i) state_q <= ST_HUNT;
          if (pos_q == POS_OP_END) begin
            case ({hdr_q[0], bit_i})
              OP_WR:   is_wr_q <= 1'b1;
              OP_RD:   is_rd_q <= 1'b1;
              default: state_q <= ST_HUNT;
            endcase
          end
          if (pos_q == POS_PHY_END && {hdr_q[PHY_W-2:0], bit_i} != phy_i)
            state_q <= ST_HUNT;
          if (pos_q == POS_LAST) begin
            state_q <= ST_HUNT;
            if (commit_o) begin
              stb_q      <= 1'b1;
              stb_addr_q <= hdr_q[REG_AW-1:0];
              stb_data_q <= {dsh_q, bit_i};
            end
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign stb_o      = stb_q;
  assign stb_addr_o = stb_addr_q;
  assign stb_data_o = stb_data_q;
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_slv_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_en_i,
  input  logic               rd_ok_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int DEPTH = 2 ** REG_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              ok_q;

  // write port and registered read port, no reset on the array
  always_ff @(posedge clk) begin
    if (wr_en_i) mem[addr_i] <= wdata_i;
    if (rd_en_i) rd_q <= mem[addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst)          ok_q <= 1'b0;
    else if (rd_en_i) ok_q <= rd_ok_i;
  end

  assign rdata_o = ok_q ? rd_q : '0;
endmodule

// File: rtl/mdio_tx.sv
module mdio_tx
  import mdio_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [DATA_W-2:0] sh_q;
  logic              o_q;
  logic              oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      o_q  <= 1'b0;
      oe_q <= 1'b0;
    end else if (start_i) begin
      oe_q <= 1'b1;
      o_q  <= 1'b0;
    end else if (load_i) begin
      o_q  <= rdata_i[DATA_W-1];
      sh_q <= rdata_i[DATA_W-2:0];
    end else if (stop_i) begin
      oe_q <= 1'b0;
      o_q  <= 1'b0;
    end else if (oe_q) begin
      o_q  <= sh_q[DATA_W-2];
      sh_q <= {sh_q[DATA_W-3:0], 1'b0};
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int REG_AW   = 3,
  parameter int IDLE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst,
  input  logic [4:0]        phy_addr_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rf_wr_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [15:0]       rf_wdata_o
);
  logic              armed;
  logic              in_frame;
  logic              rd_en;
  logic              range_ok;
  logic [REG_AW-1:0] reg_addr;
  logic              tx_start;
  logic              tx_load;
  logic              tx_stop;
  logic              commit;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  mdio_idle_det #(.IDLE_LEN(IDLE_LEN)) u_idle (
    .clk(mdc), .rst(rst), .bit_i(mdio_i), .clear_i(in_frame), .armed_o(armed)
  );

  mdio_frame_fsm #(.REG_AW(REG_AW)) u_fsm (
    .clk(mdc), .rst(rst), .bit_i(mdio_i), .armed_i(armed), .phy_i(phy_addr_i),
    .in_frame_o(in_frame), .rd_en_o(rd_en), .range_ok_o(range_ok),
    .reg_addr_o(reg_addr), .tx_start_o(tx_start), .tx_load_o(tx_load),
    .tx_stop_o(tx_stop), .commit_o(commit), .wdata_o(wdata),
    .stb_o(rf_wr_o), .stb_addr_o(rf_waddr_o), .stb_data_o(rf_wdata_o)
  );

  mdio_regfile #(.REG_AW(REG_AW)) u_rf (
    .clk(mdc), .rst(rst), .wr_en_i(commit), .addr_i(reg_addr), .wdata_i(wdata),
    .rd_en_i(rd_en), .rd_ok_i(range_ok), .rdata_o(rdata)
  );

  mdio_tx u_tx (
    .clk(mdc), .rst(rst), .start_i(tx_start), .load_i(tx_load), .stop_i(tx_stop),
    .rdata_i(rdata), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic mdc,
  input logic rst,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rf_wr_o
);
  logic [5:0] drive_run;

  always_ff @(posedge mdc) begin
    if (rst)          drive_run <= '0;
    else if (mdio_oe) drive_run <= drive_run + 6'd1;
    else              drive_run <= '0;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge mdc)
    rst |=> (!mdio_oe && !rf_wr_o));

  assert_strobe_single_R3: assert property (@(posedge mdc) disable iff (rst)
    rf_wr_o |=> !rf_wr_o);

  assert_strobe_not_driving_R3: assert property (@(posedge mdc) disable iff (rst)
    rf_wr_o |-> !mdio_oe);

  assert_turnaround_low_R4: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  assert_release_after_17_R5: assert property (@(posedge mdc) disable iff (rst)
    $fell(mdio_oe) |-> (drive_run == 6'd17));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk chk_i (
  .mdc(mdc), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rf_wr_o(rf_wr_o)
);

// File: tb/mdio_mgmt_slave_tb_top.sv
module mdio_mgmt_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REG_AW     = 3;
  localparam int IDLE_LEN   = 32;
  localparam int WD_CYCLES  = 100000;
  localparam logic [4:0] STRAP = 5'h0B;

  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;
  logic        rf_wr_o;
  logic [REG_AW-1:0] rf_waddr_o;
  logic [15:0] rf_wdata_o;
  logic        st_en = 1'b0;
  logic        st_val = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] model [8];
  bit          exp_wr = 1'b0;
  logic [REG_AW-1:0] exp_waddr;
  logic [15:0] exp_wdata;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  // shared line: slave, then station, else pull-up
  assign mdio_i = mdio_oe ? mdio_o : (st_en ? st_val : 1'b1);

  mdio_mgmt_slave #(.REG_AW(REG_AW), .IDLE_LEN(IDLE_LEN)) dut_i (
    .mdc(mdc), .rst(rst), .phy_addr_i(STRAP), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rf_wr_o(rf_wr_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // one bit period: compare outputs, then set station drive for the slot
  task automatic slot(input bit drv, input bit val, input bit eoe, input bit eo,
                      input string tag);
    @(negedge mdc);
    check(mdio_oe === eoe, tag, "mdio_oe", 32'(mdio_oe), 32'(eoe));
    if (eoe) check(mdio_o === eo, tag, "mdio_o", 32'(mdio_o), 32'(eo));
    check(rf_wr_o === exp_wr, exp_wr ? "R3" : tag, "rf_wr_o", 32'(rf_wr_o), 32'(exp_wr));
    if (exp_wr) begin
      check(rf_waddr_o === exp_waddr, "R3", "rf_waddr_o", 32'(rf_waddr_o), 32'(exp_waddr));
      check(rf_wdata_o === exp_wdata, "R3", "rf_wdata_o", 32'(rf_wdata_o), 32'(exp_wdata));
    end
    exp_wr = 1'b0;
    st_en  = drv;
    st_val = val;
  endtask

  task automatic frame(input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] data, input int pre, input string tag);
    logic [31:0] bits;
    bit is_rd;
    bit hit;
    bit in_rng;
    logic [15:0] rexp;
    is_rd  = (op == 2'b10);
    in_rng = (ra < 5'd8);
    hit    = (st == 2'b01) && (op == 2'b01 || op == 2'b10) && (phy == STRAP) && (pre >= IDLE_LEN);
    rexp   = in_rng ? model[ra[2:0]] : 16'h0000;
    bits   = {st, op, phy, ra, 2'b10, data};
    for (int i = 0; i < pre; i++) slot(1'b1, 1'b1, 1'b0, 1'b0, tag);
    for (int k = 0; k < 32; k++) begin
      bit drv;
      bit eoe;
      bit eo;
      drv = !(is_rd && k >= 14);
      eoe = is_rd && hit && k >= 15;
      eo  = (k >= 16) ? rexp[31-k] : 1'b0;
      slot(drv, bits[31-k], eoe, eo, tag);
    end
    if (hit && !is_rd && in_rng) begin
      exp_wr    = 1'b1;
      exp_waddr = ra[REG_AW-1:0];
      exp_wdata = data;
      model[ra[2:0]] = data;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    repeat (3) @(negedge mdc);
    // R1: quiet while reset is held
    check(mdio_oe === 1'b0, "R1", "mdio_oe in reset", 32'(mdio_oe), 32'd0);
    check(rf_wr_o === 1'b0, "R1", "rf_wr_o in reset", 32'(rf_wr_o), 32'd0);
    rst = 1'b0;
    slot(1'b1, 1'b1, 1'b0, 1'b0, "R1");

    frame(2'b01, 2'b01, STRAP, 5'd1, 16'hBEEF, 32, "R3");
    frame(2'b01, 2'b01, STRAP, 5'd6, 16'h1234, 32, "R3");
    frame(2'b01, 2'b10, STRAP, 5'd1, 16'h0000, 32, "R4");
    frame(2'b01, 2'b10, STRAP, 5'd6, 16'h0000, 32, "R5");
    // R2: previous frame ends in 0, only 10 ones precede this write
    frame(2'b01, 2'b01, STRAP, 5'd1, 16'h0000, 10, "R2");
    frame(2'b01, 2'b10, STRAP, 5'd1, 16'h0000, 32, "R2");
    // R6: other device address, write then read
    frame(2'b01, 2'b01, STRAP ^ 5'h04, 5'd1, 16'h5555, 32, "R6");
    frame(2'b01, 2'b10, STRAP ^ 5'h10, 5'd6, 16'h0000, 32, "R6");
    frame(2'b01, 2'b10, STRAP, 5'd1, 16'h0000, 32, "R6");
    // R7: reserved opcodes
    frame(2'b01, 2'b00, STRAP, 5'd6, 16'hAAAA, 32, "R7");
    frame(2'b01, 2'b11, STRAP, 5'd6, 16'h0F0E, 32, "R7");
    frame(2'b01, 2'b10, STRAP, 5'd6, 16'h0000, 32, "R7");
    // R8: second start bit 0
    frame(2'b00, 2'b01, STRAP, 5'd1, 16'h7070, 32, "R8");
    frame(2'b00, 2'b10, STRAP, 5'd1, 16'h0000, 32, "R8");
    frame(2'b01, 2'b10, STRAP, 5'd1, 16'h0000, 32, "R8");
    // R9: address 12 is out of range and aliases register 4 in its low bits
    frame(2'b01, 2'b01, STRAP, 5'd4, 16'h0F0F, 32, "R9");
    frame(2'b01, 2'b01, STRAP, 5'd12, 16'h7777, 32, "R9");
    frame(2'b01, 2'b10, STRAP, 5'd12, 16'h0000, 32, "R9");
    frame(2'b01, 2'b10, STRAP, 5'd4, 16'h0000, 32, "R9");
    frame(2'b01, 2'b01, STRAP, 5'd7, 16'hFFFF, 32, "R3");
    frame(2'b01, 2'b10, STRAP, 5'd7, 16'h0000, 32, "R4");
    for (int i = 0; i < 4; i++) slot(1'b1, 1'b1, 1'b0, 1'b0, "R5");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge mdc);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=end of test", WD_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule